// File: doc/BRIEF.md
# Windowed DC-Offset and Open-Tweeter Qualifier

This block sits between four channels of analog comparators and the status read path of a four-channel audio power stage. It turns raw, asynchronous comparator bits into per-channel verdicts that have been held for a whole measuring window. Two checks run side by side, each with its own window.

The DC check flags a channel whose output-offset comparator (about 2 V of magnitude) stayed asserted for the whole window. The current check counts how often a channel's peak current rose above the high threshold (about 500 mA). It flags an open tweeter when fewer than three such rises occurred.

A window opens when its function becomes active, which means its enable is set while the amplifier is out of standby. It also opens at every status read. It closes at the next read. A read therefore latches the verdict of the window that just ended and starts a fresh window in the same cycle. An overload from the short-circuit protection during a window cancels both verdicts for that window.

Each function has a three-state window controller:
- `W_IDLE`: the function is inactive.
- `W_MEASURE`: the window is open and valid.
- `W_SUPPRESSED`: an overload was seen in this window.

The controller moves between these states as follows:
- It goes to `W_IDLE` whenever the function is inactive.
- On a window start it goes to `W_MEASURE`, or to `W_SUPPRESSED` if an overload is present in that cycle.
- It goes from `W_MEASURE` to `W_SUPPRESSED` on an overload.
- It stays in `W_SUPPRESSED` until the next window start.

Top module: `dcac_fault_qualifier`

## Requirements
- R1: While reset is asserted and after it is released, with no read yet, `dc_fault`, `tw_open`, `dc_busy` and `ipk_busy` are all 0.
- R2: `dc_busy` equals `dc_en` AND `amp_on`. `ipk_busy` equals `ipk_en` AND `amp_on`. Both flags are combinational.
- R3: Comparator inputs pass through a two-flop synchroniser. Bit i of every 4-bit bus belongs to channel i. At a read, `dc_fault[i]` becomes 1 when every synchronised sample of `dc_cmp[i]` from the window's start cycle up to the cycle before the read was 1.
- R4: A single-cycle drop of `dc_cmp[i]` inside the window makes `dc_fault[i]` 0 at the read that ends that window.
- R5: A DC window starts on the first cycle that `dc_busy` is 1, or at any read while it is 1. The value latched by a read belongs to the window that ended, and the next window begins in the same cycle.
- R6: At a read, `tw_open[i]` becomes 1 when fewer than 3 rising edges of synchronised `ipk_cmp[i]` occurred in the window, and 0 when 3 or more occurred.
- R7: A comparator held high counts as one edge only. More than 3 edges saturate the count and still give 0.
- R8: If `ovl` is 1 in any cycle of a window, including the read cycle, that read latches 0 for both `dc_fault` and `tw_open`. The following window is judged normally.
- R9: At a read where a function is inactive (enable clear or `amp_on` low), that function's result bits become 0.
- R10: `dc_fault` and `tw_open` change only in the cycle after `rd_strobe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_on | input | 1 | Amplifier out of standby |
| dc_en | input | 1 | Offset check enable |
| ipk_en | input | 1 | Current check enable |
| ovl | input | 1 | Short-circuit protection active (synchronous) |
| rd_strobe | input | 1 | One-cycle status read pulse |
| dc_cmp | input | 4 | Raw offset comparators, bit i = channel i |
| ipk_cmp | input | 4 | Raw peak-current-above-high-threshold comparators |
| dc_fault | output | 4 | Latched excess-offset verdicts |
| tw_open | output | 4 | Latched open-tweeter verdicts |
| dc_busy | output | 1 | Offset check active |
| ipk_busy | output | 1 | Current check active |

## Verification
The offset path is exercised with three input patterns:
- a comparator held high for the whole window;
- a comparator held high with one sample dropped;
- a comparator held low.

These separate a window-wide AND from a last-sample or any-sample check.

The current path drives per-channel pulse trains of 3, 2 and 5 edges, plus one level held high. These show an exact threshold of three, saturation, and edge counting rather than level counting.

Further sequences cover a one-cycle overload, a read while in standby, and a pair of reads back to back. They separate verdict suppression from sticky failure, and the previous window's verdict from the current window's.

// File: rtl/dcac_qual_pkg.sv
package dcac_qual_pkg;
    typedef enum logic [1:0] {
        W_IDLE       = 2'd0,
        W_MEASURE    = 2'd1,
        W_SUPPRESSED = 2'd2
    } win_state_t;
endpackage

// File: rtl/dcac_sync.sv
module dcac_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dcac_window.sv
module dcac_window
    import dcac_qual_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rd_strobe,
    input  logic ovl,
    output logic win_start,
    output logic verdict_ok
);
    win_state_t state, state_nx;
    logic       active_q;

    // a window starts when the function becomes active or at a read
    assign win_start = active && (!active_q || rd_strobe);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            active_q <= 1'b0;
        end else begin
            state    <= state_nx;
            active_q <= active;
        end
    end

    always_comb begin
        state_nx = state;
        if (!active) begin
            state_nx = W_IDLE;
        end else if (win_start) begin
            state_nx = ovl ? W_SUPPRESSED : W_MEASURE;
        end else begin
            unique case (state)
                W_IDLE:       state_nx = W_IDLE;
                W_MEASURE:    state_nx = ovl ? W_SUPPRESSED : W_MEASURE;
                W_SUPPRESSED: state_nx = W_SUPPRESSED;
                default:      state_nx = W_IDLE;
            endcase
        end
    end

    always_comb begin
        verdict_ok = 1'b0;
        unique case (state)
            W_IDLE:       verdict_ok = 1'b0;
            W_MEASURE:    verdict_ok = active && !ovl;
            W_SUPPRESSED: verdict_ok = 1'b0;
            default:      verdict_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcac_chan.sv
module dcac_chan #(
    parameter int MIN_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dc_s,
    input  logic ipk_rise,
    input  logic dc_start,
    input  logic ipk_start,
    input  logic dc_ok,
    input  logic ipk_ok,
    input  logic rd_strobe,
    output logic dc_fault,
    output logic tw_open
);
    localparam int CNT_W = $clog2(MIN_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSES);

    logic             dc_all;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_all <= 1'b0;
        end else if (dc_start) begin
            dc_all <= dc_s;
        end else begin
            dc_all <= dc_all & dc_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ipk_start) begin
            cnt <= CNT_W'(ipk_rise);
        end else if (ipk_rise && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_fault <= 1'b0;
            tw_open  <= 1'b0;
        end else if (rd_strobe) begin
            dc_fault <= dc_ok && dc_all;
            tw_open  <= ipk_ok && (cnt < CNT_MAX);
        end
    end
endmodule

// File: rtl/dcac_fault_qualifier.sv
module dcac_fault_qualifier #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSES  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           amp_on,
    input  logic           dc_en,
    input  logic           ipk_en,
    input  logic           ovl,
    input  logic           rd_strobe,
    input  logic [NCH-1:0] dc_cmp,
    input  logic [NCH-1:0] ipk_cmp,
    output logic [NCH-1:0] dc_fault,
    output logic [NCH-1:0] tw_open,
    output logic           dc_busy,
    output logic           ipk_busy
);
    logic [NCH-1:0] dc_s, ipk_s, ipk_prev, ipk_rise;
    logic           dc_start, ipk_start, dc_ok, ipk_ok;

    assign dc_busy  = dc_en && amp_on;
    assign ipk_busy = ipk_en && amp_on;

    dcac_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_dc (
        .clk(clk), .rst_n(rst_n), .din(dc_cmp), .dout(dc_s)
    );

    dcac_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_ipk (
        .clk(clk), .rst_n(rst_n), .din(ipk_cmp), .dout(ipk_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ipk_prev <= '0;
        else        ipk_prev <= ipk_s;
    end

    assign ipk_rise = ipk_s & ~ipk_prev;

    dcac_window u_win_dc (
        .clk(clk), .rst_n(rst_n), .active(dc_busy), .rd_strobe(rd_strobe),
        .ovl(ovl), .win_start(dc_start), .verdict_ok(dc_ok)
    );

    dcac_window u_win_ipk (
        .clk(clk), .rst_n(rst_n), .active(ipk_busy), .rd_strobe(rd_strobe),
        .ovl(ovl), .win_start(ipk_start), .verdict_ok(ipk_ok)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dcac_chan #(.MIN_PULSES(MIN_PULSES)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .dc_s(dc_s[c]), .ipk_rise(ipk_rise[c]),
            .dc_start(dc_start), .ipk_start(ipk_start),
            .dc_ok(dc_ok), .ipk_ok(ipk_ok), .rd_strobe(rd_strobe),
            .dc_fault(dc_fault[c]), .tw_open(tw_open[c])
        );
    end
endmodule

// File: rtl/dcac_fault_qualifier_chk.sv
module dcac_fault_qualifier_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           amp_on,
    input logic           dc_en,
    input logic           ipk_en,
    input logic           ovl,
    input logic           rd_strobe,
    input logic [NCH-1:0] dc_fault,
    input logic [NCH-1:0] tw_open,
    input logic           dc_busy,
    input logic           ipk_busy
);
    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ($stable(dc_fault) && $stable(tw_open)));

    // R8
    ovl_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ovl) |=> (dc_fault == '0 && tw_open == '0));

    // R9
    dc_idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !dc_busy) |=> (dc_fault == '0));

    // R9
    ipk_idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !ipk_busy) |=> (tw_open == '0));

    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_on |-> (!dc_busy && !ipk_busy));
endmodule

bind dcac_fault_qualifier dcac_fault_qualifier_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .amp_on(amp_on), .dc_en(dc_en), .ipk_en(ipk_en),
    .ovl(ovl), .rd_strobe(rd_strobe), .dc_fault(dc_fault), .tw_open(tw_open),
    .dc_busy(dc_busy), .ipk_busy(ipk_busy)
);

// File: tb/sim_dcac_fault_qualifier.sv
module sim_dcac_fault_qualifier;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       amp_on = 1'b0, dc_en = 1'b0, ipk_en = 1'b0, ovl = 1'b0, rd_strobe = 1'b0;
    logic [3:0] dc_cmp = '0, ipk_cmp = '0;
    logic [3:0] dc_fault, tw_open;
    logic       dc_busy, ipk_busy;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcac_fault_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .amp_on(amp_on), .dc_en(dc_en), .ipk_en(ipk_en),
        .ovl(ovl), .rd_strobe(rd_strobe), .dc_cmp(dc_cmp), .ipk_cmp(ipk_cmp),
        .dc_fault(dc_fault), .tw_open(tw_open), .dc_busy(dc_busy), .ipk_busy(ipk_busy)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated at each rising edge
    logic [3:0] h_dc [$];
    logic [3:0] h_ipk [$];
    int  m_st_dc = 0, m_st_ipk = 0;
    bit  m_aq_dc = 0, m_aq_ipk = 0;
    bit  m_all [4];
    int  m_cnt [4];
    logic [3:0] m_dc = '0, m_tw = '0;

    initial begin
        for (int k = 0; k < 3; k++) begin h_dc.push_back('0); h_ipk.push_back('0); end
        for (int i = 0; i < 4; i++) begin m_all[i] = 0; m_cnt[i] = 0; end
    end

    function automatic int next_state(int st, bit act, bit start, bit ov);
        if (!act) return 0;
        if (start) return ov ? 2 : 1;
        if (st == 1 && ov) return 2;
        return st;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st_dc = 0; m_st_ipk = 0; m_aq_dc = 0; m_aq_ipk = 0; m_dc = '0; m_tw = '0;
            for (int i = 0; i < 4; i++) begin m_all[i] = 0; m_cnt[i] = 0; end
            for (int k = 0; k < 3; k++) begin h_dc[k] = '0; h_ipk[k] = '0; end
        end else begin
            bit a_dc, a_ipk, s_dc, s_ipk, ok_dc, ok_ipk;
            logic [3:0] sd, rise;
            a_dc  = dc_en && amp_on;
            a_ipk = ipk_en && amp_on;
            s_dc  = a_dc && (!m_aq_dc || rd_strobe);
            s_ipk = a_ipk && (!m_aq_ipk || rd_strobe);
            ok_dc  = (m_st_dc == 1) && !ovl && a_dc;
            ok_ipk = (m_st_ipk == 1) && !ovl && a_ipk;
            sd   = h_dc[1];
            rise = h_ipk[1] & ~h_ipk[2];
            for (int i = 0; i < 4; i++) begin
                if (rd_strobe) begin
                    m_dc[i] = ok_dc && m_all[i];
                    m_tw[i] = ok_ipk && (m_cnt[i] < 3);
                end
                m_all[i] = s_dc ? sd[i] : (m_all[i] && sd[i]);
                if (s_ipk) m_cnt[i] = int'(rise[i]);
                else if (rise[i] && m_cnt[i] < 3) m_cnt[i]++;
            end
            m_st_dc  = next_state(m_st_dc, a_dc, s_dc, ovl);
            m_st_ipk = next_state(m_st_ipk, a_ipk, s_ipk, ovl);
            m_aq_dc = a_dc; m_aq_ipk = a_ipk;
            void'(h_dc.pop_back()); h_dc.push_front(dc_cmp);
            void'(h_ipk.pop_back()); h_ipk.push_front(ipk_cmp);
        end
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            check("R3 model dc_fault", dc_fault, m_dc);
            check("R6 model tw_open", tw_open, m_tw);
            check("R2 model busy", {2'b00, dc_busy, ipk_busy},
                  {2'b00, dc_en && amp_on, ipk_en && amp_on});
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask

    initial begin : watchdog
        for (int k = 0; k < 20000; k++) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        dc_cmp = 4'b0101;
        cyc(3);
        // R1 reset state
        check("R1 dc_fault in reset", dc_fault, 4'b0000);
        check("R1 tw_open in reset", tw_open, 4'b0000);
        rst_n = 1'b1;
        cyc(2);
        check("R1 after reset", {dc_fault, tw_open}[3:0] | dc_fault, 4'b0000);
        // R2 activity flags
        dc_en = 1'b1; cyc(1);
        check("R2 busy in standby", {2'b00, dc_busy, ipk_busy}, 4'b0000);
        dc_en = 1'b0; amp_on = 1'b1; cyc(1);
        check("R2 busy with enables clear", {2'b00, dc_busy, ipk_busy}, 4'b0000);
        dc_en = 1'b1; cyc(1);
        check("R2 dc busy", {2'b00, dc_busy, ipk_busy}, 4'b0010);
        // R4 one-cycle drop on channel 2
        cyc(3);
        dc_cmp = 4'b0001; cyc(1); dc_cmp = 4'b0101;
        cyc(6);
        check("R5 no verdict before read", dc_fault, 4'b0000);
        do_read();
        check("R4 glitched channel cleared, R3 steady set", dc_fault, 4'b0001);
        cyc(8);
        do_read();
        check("R5 new window from read", dc_fault, 4'b0101);
        // R10 hold without read
        dc_cmp = 4'b0000; cyc(6);
        check("R10 dc_fault holds", dc_fault, 4'b0101);
        // current check: ch0 3 edges, ch1 2, ch2 held high, ch3 5
        dc_en = 1'b0; ipk_en = 1'b1; cyc(2);
        for (int k = 0; k < 5; k++) begin
            ipk_cmp = {1'b1, 1'b1, (k < 2), (k < 3)};
            cyc(1);
            ipk_cmp = 4'b0100;
            cyc(2);
        end
        cyc(5);
        check("R10 tw_open holds before read", tw_open, 4'b0000);
        do_read();
        check("R6 R7 edge counts", tw_open, 4'b0110);
        check("R9 dc inactive at read", dc_fault, 4'b0000);
        // R8 overload cancels both
        ipk_cmp = 4'b0000; dc_cmp = 4'b1111; dc_en = 1'b1;
        cyc(4);
        ovl = 1'b1; cyc(1); ovl = 1'b0;
        cyc(4);
        do_read();
        check("R8 dc cancelled", dc_fault, 4'b0000);
        check("R8 tw cancelled", tw_open, 4'b0000);
        cyc(6);
        do_read();
        check("R8 next window dc", dc_fault, 4'b1111);
        check("R8 next window tw", tw_open, 4'b1111);
        // R9 standby
        amp_on = 1'b0; cyc(2);
        check("R2 standby busy", {2'b00, dc_busy, ipk_busy}, 4'b0000);
        do_read();
        check("R9 standby dc", dc_fault, 4'b0000);
        check("R9 standby tw", tw_open, 4'b0000);
        cyc(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule